// File: doc/BRIEF.md
# Split-Score Decimal Readout Converter

This block turns a game score that is kept as two independent 8-bit halves into decimal digits for a four-digit display. Each half goes through its own serial shift-and-add-3 engine. The engine turns the binary value into three BCD digits. The two low-order digits of each half are then joined, upper half first, to form a readout that runs from 0000 to 9999.

A one-cycle start strobe launches a conversion. The strobe captures both halves, and the two engines then run side by side for one cycle per input bit. When both engines have finished, the display digits, the raw three-digit result of each half and a saturation flag per half are registered together, and done pulses for one cycle. The outputs then hold their values until the next conversion completes.

A half is expected to lie in 0..99. A larger value sets that half's saturation flag and shows 99 in that half's two display digits. The raw three-digit result of the half still reports the true value.

Top module: `score_bcd_display`

## Requirements
- R1: While rst is high at a rising clock edge, the next state clears bcd_out, raw_hi, raw_lo, sat_hi, sat_lo and done to zero.
- R2: raw_hi and raw_lo hold the three BCD digits of the captured halves. The hundreds digit sits in [11:8], the tens in [7:4] and the units in [3:0], each digit 0..9. For example, 0 gives 12'h000, 99 gives 12'h099 and 255 gives 12'h255.
- R3: bcd_out[15:12] is the tens digit of the upper half, [11:8] its units digit, [7:4] the tens digit of the lower half and [3:0] its units digit. For example, halves 12 and 34 give 16'h1234.
- R4: A half greater than 99 sets its own flag (sat_hi or sat_lo) and shows 4'h9,4'h9 in its two bcd_out digits. The other half's flag and digits are not affected.
- R5: done is high for exactly one cycle. That cycle starts at the 9th rising edge after the edge that samples start (the bit count plus one).
- R6: bcd_out, raw_hi, raw_lo, sat_hi and sat_lo change only at the edge that raises done, and hold their values at every other edge.
- R7: A start pulse that arrives while a conversion is in progress is ignored. It produces no extra done pulse, and the results come from the earlier start.
- R8: The halves are sampled only at the edge that accepts start. Changing them later in the conversion has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, honoured when idle |
| half_hi | input | 8 | Upper score half (thousands, hundreds) |
| half_lo | input | 8 | Lower score half (tens, units) |
| bcd_out | output | 16 | Four display digits, most significant first |
| raw_hi | output | 12 | Three BCD digits of the upper half |
| raw_lo | output | 12 | Three BCD digits of the lower half |
| sat_hi | output | 1 | Upper half exceeded 99 |
| sat_lo | output | 1 | Lower half exceeded 99 |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that the halves stay within the 8-bit range, so every BCD nibble stays at 9 or below after each shift and nothing carries out of the top digit. They also assume that start is a pulse that the control logic alone gates, so an engine never sees a reload while it is running. The stimulus drives every half value from 0 to 255 in a full sweep and always raises start on a falling edge. It sends one extra start in the middle of a run, on purpose, to show that the block ignores it. It changes the halves after the sampling edge to show that the captured values are the ones used.

// File: rtl/score_bcd_pkg.sv
package score_bcd_pkg;

  // Number of decimal digits needed for the largest unsigned value of width w
  function automatic int bcd_digits(input int w);
    longint unsigned top_val;
    longint unsigned lim;
    int n;
    top_val = (longint'(1) << w) - 1;
    lim = 10;
    n = 1;
    while (top_val >= lim) begin
      n++;
      lim = lim * 10;
    end
    return n;
  endfunction

  typedef enum logic {
    CV_IDLE = 1'b0,
    CV_RUN  = 1'b1
  } cv_state_e;

endpackage

// File: rtl/dd_engine.sv
module dd_engine
  import score_bcd_pkg::*;
#(
  parameter int W = 8,
  parameter int D = bcd_digits(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   value,
  output logic           fin,
  output logic [4*D-1:0] bcd
);
  localparam int BW = 4 * D;
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]   sh;
  logic [BW-1:0]  acc;
  logic [BW-1:0]  adj;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [BW+W:0]  nxt;
  logic           spill;

  // correction step: each digit of 5 or more gets 3 added before the shift
  for (genvar g = 0; g < D; g++) begin : g_fix
    assign adj[4*g +: 4] = (acc[4*g +: 4] >= 4'd5) ? (acc[4*g +: 4] + 4'd3)
                                                   : acc[4*g +: 4];
  end

  assign nxt   = {adj, sh, 1'b0};
  assign spill = nxt[BW+W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      acc  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        sh   <= value;
        acc  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        acc <= nxt[BW+W-1:W];
        sh  <= nxt[W-1:0];
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign bcd = acc;

  // digits stay decimal through every iteration
  for (genvar g = 0; g < D; g++) begin : g_chk
    assert_nibble_legal_R2: assert property (@(posedge clk) disable iff (rst)
      acc[4*g +: 4] <= 4'd9);
  end

  // nothing is lost out of the top digit during a shift
  assert_no_spill_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !spill);

  assert_fin_single_R5: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

  assert_no_reload_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import score_bcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fin_hi,
  input  logic fin_lo,
  output logic accept,
  output logic capture
);
  cv_state_e state;

  assign accept  = start && (state == CV_IDLE);
  assign capture = fin_hi && fin_lo && (state == CV_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CV_IDLE;
    end else if (accept) begin
      state <= CV_RUN;
    end else if (capture) begin
      state <= CV_IDLE;
    end
  end

  // both engines are launched together, so they must finish together
  assert_lockstep_R5: assert property (@(posedge clk) disable iff (rst)
    fin_hi == fin_lo);

  assert_fin_in_run_R7: assert property (@(posedge clk) disable iff (rst)
    fin_hi |-> (state == CV_RUN));

endmodule

// File: rtl/digit_pick.sv
module digit_pick #(
  parameter int D = 3
) (
  input  logic [4*D-1:0] raw,
  output logic [7:0]     pair,
  output logic           sat
);
  // a half above 99 has a non-zero digit above the tens
  if (D > 2) begin : g_wide
    assign sat = |raw[4*D-1:8];
  end else begin : g_narrow
    assign sat = 1'b0;
  end

  assign pair = sat ? 8'h99 : raw[7:0];

endmodule

// File: rtl/score_bcd_display.sv
module score_bcd_display
  import score_bcd_pkg::*;
#(
  parameter int W = 8,
  parameter int D = bcd_digits(W),
  parameter int RAW_W = 4 * D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     half_hi,
  input  logic [W-1:0]     half_lo,
  output logic [15:0]      bcd_out,
  output logic [RAW_W-1:0] raw_hi,
  output logic [RAW_W-1:0] raw_lo,
  output logic             sat_hi,
  output logic             sat_lo,
  output logic             done
);
  localparam int HALVES = 2;

  logic                 accept;
  logic                 capture;
  logic [HALVES-1:0]    fin;
  logic [RAW_W-1:0]     eng_bcd [HALVES];
  logic [7:0]           pair    [HALVES];
  logic [HALVES-1:0]    sat;
  logic [W-1:0]         half_in [HALVES];

  assign half_in[0] = half_lo;
  assign half_in[1] = half_hi;

  seq_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .fin_hi  (fin[1]),
    .fin_lo  (fin[0]),
    .accept  (accept),
    .capture (capture)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    dd_engine #(.W(W), .D(D)) u_eng (
      .clk   (clk),
      .rst   (rst),
      .load  (accept),
      .value (half_in[h]),
      .fin   (fin[h]),
      .bcd   (eng_bcd[h])
    );

    digit_pick #(.D(D)) u_pick (
      .raw  (eng_bcd[h]),
      .pair (pair[h]),
      .sat  (sat[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcd_out <= '0;
      raw_hi  <= '0;
      raw_lo  <= '0;
      sat_hi  <= 1'b0;
      sat_lo  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= capture;
      if (capture) begin
        bcd_out <= {pair[1], pair[0]};
        raw_hi  <= eng_bcd[1];
        raw_lo  <= eng_bcd[0];
        sat_hi  <= sat[1];
        sat_lo  <= sat[0];
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(bcd_out) && $stable(raw_hi) && $stable(raw_lo)
               && $stable(sat_hi) && $stable(sat_lo)));

  assert_sat_shows_99_R4: assert property (@(posedge clk) disable iff (rst)
    (done && sat_hi) |-> (bcd_out[15:8] == 8'h99));

  assert_lo_follows_raw_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !sat_lo) |-> (bcd_out[7:0] == raw_lo[7:0]));

  assert_hi_follows_raw_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !sat_hi) |-> (bcd_out[15:8] == raw_hi[7:0]));

endmodule

// File: tb/sim_score_bcd_display.sv
module sim_score_bcd_display;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  half_hi = '0;
  logic [7:0]  half_lo = '0;
  logic [15:0] bcd_out;
  logic [11:0] raw_hi;
  logic [11:0] raw_lo;
  logic        sat_hi;
  logic        sat_lo;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  score_bcd_display u0 (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .half_hi (half_hi),
    .half_lo (half_lo),
    .bcd_out (bcd_out),
    .raw_hi  (raw_hi),
    .raw_lo  (raw_lo),
    .sat_hi  (sat_hi),
    .sat_lo  (sat_lo),
    .done    (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] to_bcd3(input int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] shown(input int v);
    return (v > 99) ? 8'h99 : to_bcd3(v)[7:0];
  endfunction

  // start a conversion; scramble changes the halves after the sampling edge (R8)
  task automatic convert(input int h, input int l, input bit scramble);
    int cnt;
    @(negedge clk);
    half_hi = 8'(h);
    half_lo = 8'(l);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      half_hi = ~8'(h);
      half_lo = ~8'(l);
    end
    cnt = 1;
    while (!done && cnt < 30) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 10, "R5 latency", 32'(cnt), 32'd10);
    chk(raw_hi == to_bcd3(h), "R2 raw_hi", 32'(raw_hi), 32'(to_bcd3(h)));
    chk(raw_lo == to_bcd3(l), "R2 raw_lo", 32'(raw_lo), 32'(to_bcd3(l)));
    chk(bcd_out == {shown(h), shown(l)}, "R3/R4 bcd_out", 32'(bcd_out),
        32'({shown(h), shown(l)}));
    chk(sat_hi == (h > 99), "R4 sat_hi", 32'(sat_hi), 32'(h > 99));
    chk(sat_lo == (l > 99), "R4 sat_lo", 32'(sat_lo), 32'(l > 99));
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bcd_out == 16'h0 && raw_hi == 12'h0 && raw_lo == 12'h0,
        "R1 reset digits", 32'({bcd_out, raw_lo[3:0]}), 32'd0);
    chk(!sat_hi && !sat_lo && !done, "R1 reset flags",
        32'({sat_hi, sat_lo, done}), 32'd0);
  endtask

  task automatic t_known();
    convert(0, 0, 1'b0);
    convert(99, 99, 1'b0);
    convert(255, 255, 1'b0);
    convert(12, 34, 1'b0);
    convert(7, 5, 1'b0);
    convert(45, 200, 1'b0);
    convert(100, 9, 1'b0);
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 256; v++) begin
      convert(v, 255 - v, 1'b0);
    end
  endtask

  task automatic t_hold();
    logic [15:0] b;
    logic [11:0] rh;
    logic [11:0] rl;
    convert(56, 78, 1'b0);
    b = bcd_out;
    rh = raw_hi;
    rl = raw_lo;
    half_hi = 8'd3;
    half_lo = 8'd4;
    repeat (6) @(negedge clk);
    chk(bcd_out == b && raw_hi == rh && raw_lo == rl, "R6 hold without start",
        32'(bcd_out), 32'(b));
    chk(done == 1'b0, "R6 no done without start", 32'(done), 32'd0);
  endtask

  task automatic t_sample();
    convert(40, 60, 1'b1);
    chk(bcd_out == 16'h4060, "R8 halves sampled at start", 32'(bcd_out), 32'h4060);
  endtask

  task automatic t_busy();
    int dones;
    @(negedge clk);
    half_hi = 8'd20;
    half_lo = 8'd30;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    half_hi = 8'd88;
    half_lo = 8'd88;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    repeat (25) begin
      @(negedge clk);
      if (done) begin
        dones++;
        chk(bcd_out == 16'h2030, "R7 result from first start", 32'(bcd_out),
            32'h2030);
      end
    end
    chk(dones == 1, "R7 single done", 32'(dones), 32'd1);
  endtask

  initial begin
    t_reset();
    t_known();
    t_sweep();
    t_hold();
    t_sample();
    t_busy();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule